// File: doc/BRIEF.md
# Operand Address Calculation Unit

This unit turns an addressing-mode code and its operands into a 32-bit operand address for a processor datapath. It covers plain register-indirect addressing, register-indirect with automatic step-up after use or step-down before use, a signed 16-bit offset from a base, a base plus a signed 8-bit offset plus a scaled index, and absolute addresses in short or long form. The two offset modes can take the program counter as their base instead of an address register.

For the stepping modes the unit also returns the updated address-register value and a strobe that tells the register file to write it back. The step size follows the operand size. Each request is presented on one cycle with `req_valid_i` high. The results come out of one register stage, one cycle later. All arithmetic wraps modulo 2^32.

Top module: `agu_core`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `res_valid_o`, `wb_en_o`, `ea_o` and `wb_val_o` are all zero.
- R2: With mode code 0 (plain indirect), `ea_o` equals `areg_i` and `wb_en_o` stays low.
- R3: With mode code 1 (step after use), `ea_o` equals `areg_i`. `wb_en_o` is high and `wb_val_o` equals `areg_i` plus the step. The step is 1, 2 or 4 for `size_i` values 0, 1 and 2; the value 3 also steps by 4.
- R4: With mode code 2 (step before use), `wb_val_o` equals `areg_i` minus the step of R3, `ea_o` equals `wb_val_o`, and `wb_en_o` is high.
- R5: With mode code 3 (offset), `ea_o` equals the base plus `ext0_i` taken as a signed 16-bit value.
- R6: With mode code 4 (indexed), `ea_o` equals the base plus `ext0_i[7:0]` sign-extended, plus the index scaled by 1, 2, 4 or 8 for `idx_scale_i` values 0 to 3. When `idx_long_i` is 0, the index is `idx_i[15:0]` sign-extended to 32 bits before scaling. When `idx_long_i` is 1, the index is all 32 bits of `idx_i`.
- R7: Mode code 5 gives `ea_o` as `ext0_i` sign-extended to 32 bits. Mode code 6 gives `ea_o` as `{ext0_i, ext1_i}`, with `ext0_i` as the upper half.
- R8: In modes 3 and 4, `pc_sel_i` = 1 makes `pc_i` the base instead of `areg_i`, and `wb_en_o` stays low.
- R9: All sums and differences wrap modulo 2^32. For example, mode 2 with `areg_i` = 0 and a long operand gives 0xFFFFFFFC.
- R10: Results appear exactly one cycle after the request. After a cycle with `req_valid_i` low, `res_valid_o` and `wb_en_o` are low on the next cycle.
- R11: `pc_sel_i` has no effect in modes 0, 1, 2, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| mode_i | input | 3 | Addressing-mode code, 0..6 |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| pc_sel_i | input | 1 | Use PC as base in offset/indexed modes |
| areg_i | input | 32 | Address register value |
| pc_i | input | 32 | Program counter value |
| idx_i | input | 32 | Index register value |
| idx_long_i | input | 1 | Index width: 0 low 16 bits, 1 all 32 bits |
| idx_scale_i | input | 2 | Index scale exponent (x1,x2,x4,x8) |
| ext0_i | input | 16 | First extension word |
| ext1_i | input | 16 | Second extension word |
| res_valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Address register write-back strobe |
| wb_val_o | output | 32 | Write-back value |

## Verification
Every result is due one clock edge after its request. The address, the write-back strobe and the write-back value all come out of the same register stage. The bench drives each request on a falling edge, lets exactly one rising edge pass, and compares all four outputs on the following falling edge. After each idle cycle the bench checks that both valid and write-back are low. Wrap-around, sign extension of short indexes and offsets, and the PC-base case are driven as directed cases. These sit among seeded random requests.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AW = 32;
    localparam int EW = 16;

    typedef enum logic [2:0] {
        AM_IND    = 3'd0,
        AM_POSTUP = 3'd1,
        AM_PREDN  = 3'd2,
        AM_OFS    = 3'd3,
        AM_IDX    = 3'd4,
        AM_ABSS   = 3'd5,
        AM_ABSL   = 3'd6
    } amode_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic          wb;
        logic [AW-1:0] wbv;
    } agu_res_t;
endpackage

// File: rtl/agu_step_gen.sv
module agu_step_gen #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_i,
    output logic [AW-1:0] step_o
);
    always_comb begin
        unique case (size_i)
            2'd0:    step_o = AW'(1);
            2'd1:    step_o = AW'(2);
            default: step_o = AW'(4);
        endcase
    end
endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler #(
    parameter int AW = 32,
    parameter int HW = 16,
    parameter int SCALES = 4
) (
    input  logic [AW-1:0]              idx_i,
    input  logic                       long_i,
    input  logic [$clog2(SCALES)-1:0]  scale_i,
    output logic [AW-1:0]              scaled_o
);
    localparam int SW = $clog2(SCALES);
    logic [AW-1:0] ext_idx;
    logic [AW-1:0] shifted [SCALES];

    always_comb begin
        if (long_i) ext_idx = idx_i;
        else        ext_idx = {{(AW-HW){idx_i[HW-1]}}, idx_i[HW-1:0]};
    end

    for (genvar s = 0; s < SCALES; s++) begin : g_shift
        assign shifted[s] = ext_idx << s;
    end

    always_comb begin
        scaled_o = '0;
        for (int s = 0; s < SCALES; s++) begin
            if (scale_i == SW'(s)) scaled_o = shifted[s];
        end
    end
endmodule

// File: rtl/agu_core.sv
module agu_core
    import agu_pkg::*;
#(
    parameter int ADDR_W = agu_pkg::AW,
    parameter int EXT_W  = agu_pkg::EW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic              pc_sel_i,
    input  logic [ADDR_W-1:0] areg_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic              idx_long_i,
    input  logic [1:0]        idx_scale_i,
    input  logic [EXT_W-1:0]  ext0_i,
    input  logic [EXT_W-1:0]  ext1_i,
    output logic              res_valid_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    localparam int D8W = 8;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] idx_scaled;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs16;
    logic [ADDR_W-1:0] ofs8;
    agu_res_t          res_d, res_q;

    agu_step_gen #(.AW(ADDR_W)) u_step (
        .size_i (size_i),
        .step_o (step)
    );

    agu_index_scaler #(.AW(ADDR_W), .HW(EXT_W), .SCALES(4)) u_idx (
        .idx_i    (idx_i),
        .long_i   (idx_long_i),
        .scale_i  (idx_scale_i),
        .scaled_o (idx_scaled)
    );

    assign base  = pc_sel_i ? pc_i : areg_i;
    assign ofs16 = {{(ADDR_W-EXT_W){ext0_i[EXT_W-1]}}, ext0_i};
    assign ofs8  = {{(ADDR_W-D8W){ext0_i[D8W-1]}}, ext0_i[D8W-1:0]};

    always_comb begin
        res_d     = '0;
        res_d.vld = req_valid_i;
        if (req_valid_i) begin
            unique case (amode_e'(mode_i))
                AM_IND: res_d.ea = areg_i;
                AM_POSTUP: begin
                    res_d.ea  = areg_i;
                    res_d.wb  = 1'b1;
                    res_d.wbv = areg_i + step;
                end
                AM_PREDN: begin
                    res_d.ea  = areg_i - step;
                    res_d.wb  = 1'b1;
                    res_d.wbv = areg_i - step;
                end
                AM_OFS:  res_d.ea = base + ofs16;
                AM_IDX:  res_d.ea = base + ofs8 + idx_scaled;
                AM_ABSS: res_d.ea = ofs16;
                AM_ABSL: res_d.ea = {ext0_i, ext1_i};
                default: res_d.ea = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign res_valid_o = res_q.vld;
    assign ea_o        = res_q.ea;
    assign wb_en_o     = res_q.wb;
    assign wb_val_o    = res_q.wbv;

    // R10
    resp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> res_valid_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!res_valid_o && !wb_en_o));

    // R4
    predec_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mode_i == 3'd2) |=> (wb_en_o && ea_o == wb_val_o));

    // R3
    postinc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mode_i == 3'd1) |=>
            (wb_en_o && ea_o == $past(areg_i) &&
             (wb_val_o - ea_o) == ((($past(size_i)) == 2'd0) ? 32'd1 :
                                   (($past(size_i)) == 2'd1) ? 32'd2 : 32'd4)));

    // R8
    pc_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && pc_sel_i && (mode_i == 3'd3 || mode_i == 3'd4)) |=> !wb_en_o);

    // R2
    ind_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mode_i == 3'd0) |=> (!wb_en_o && ea_o == $past(areg_i)));
endmodule

// File: tb/agu_core_tb.sv
module agu_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        pc_sel = 1'b0;
    logic [31:0] areg = '0, pc = '0, idx = '0;
    logic        idx_long = 1'b0;
    logic [1:0]  idx_scale = '0;
    logic [15:0] ext0 = '0, ext1 = '0;
    logic        res_valid, wb_en;
    logic [31:0] ea, wb_val;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_core dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .mode_i(mode),
        .size_i(size), .pc_sel_i(pc_sel), .areg_i(areg), .pc_i(pc), .idx_i(idx),
        .idx_long_i(idx_long), .idx_scale_i(idx_scale), .ext0_i(ext0), .ext1_i(ext1),
        .res_valid_o(res_valid), .ea_o(ea), .wb_en_o(wb_en), .wb_val_o(wb_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] model_ea(input logic [2:0] m, input logic [1:0] s,
            input logic ps, input logic [31:0] a, input logic [31:0] p,
            input logic [31:0] x, input logic xl, input logic [1:0] sc,
            input logic [15:0] e0, input logic [15:0] e1);
        logic [31:0] b, xv;
        b  = ps ? p : a;
        xv = xl ? x : {{16{x[15]}}, x[15:0]};
        case (m)
            3'd0, 3'd1: return a;
            3'd2:       return a - step_of(s);
            3'd3:       return b + {{16{e0[15]}}, e0};
            3'd4:       return b + {{24{e0[7]}}, e0[7:0]} + (xv << sc);
            3'd5:       return {{16{e0[15]}}, e0};
            3'd6:       return {e0, e1};
            default:    return 32'd0;
        endcase
    endfunction

    task automatic run_req(input string tag, input logic [2:0] m, input logic [1:0] s,
            input logic ps, input logic [31:0] a, input logic [31:0] p,
            input logic [31:0] x, input logic xl, input logic [1:0] sc,
            input logic [15:0] e0, input logic [15:0] e1);
        logic [31:0] exp_ea, exp_wbv;
        logic        exp_wb;
        req_valid = 1'b1; mode = m; size = s; pc_sel = ps; areg = a; pc = p;
        idx = x; idx_long = xl; idx_scale = sc; ext0 = e0; ext1 = e1;
        exp_ea  = model_ea(m, s, ps, a, p, x, xl, sc, e0, e1);
        exp_wb  = (m == 3'd1) || (m == 3'd2);
        exp_wbv = (m == 3'd1) ? a + step_of(s) : (m == 3'd2) ? a - step_of(s) : 32'd0;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " ea"}, ea, exp_ea);
        chk({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, exp_wb});
        if (exp_wb) chk({tag, " wb_val"}, wb_val, exp_wbv);
        chk({tag, " valid R10"}, {31'd0, res_valid}, 32'd1);
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 idle valid", {31'd0, res_valid}, 32'd0);
        chk("R10 idle wb_en", {31'd0, wb_en}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1 ea", ea, 32'd0);
        chk("R1 wb_val", wb_val, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {31'd0, res_valid}, 32'd0);

        run_req("R2 ind", 3'd0, 2'd2, 1'b0, 32'h1234_5678, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R3 post byte", 3'd1, 2'd0, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R3 post word", 3'd1, 2'd1, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R3 R9 post long wrap", 3'd1, 2'd2, 1'b0, 32'hFFFF_FFFE, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R4 R9 pre long wrap", 3'd2, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R4 pre byte", 3'd2, 2'd0, 1'b0, 32'h0000_2000, 32'h0, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        idle_cycle();
        run_req("R5 ofs neg", 3'd3, 2'd1, 1'b0, 32'h0000_0100, 32'h0, 32'h0, 1'b0, 2'd0, 16'hFFF0, 16'h0);
        run_req("R6 idx word neg x8", 3'd4, 2'd1, 1'b0, 32'h0001_0000, 32'h0, 32'h7777_8000, 1'b0, 2'd3, 16'h0080, 16'h0);
        run_req("R6 idx long x2", 3'd4, 2'd1, 1'b0, 32'h0001_0000, 32'h0, 32'h0010_0000, 1'b1, 2'd1, 16'h007F, 16'h0);
        run_req("R7 abs short", 3'd5, 2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0, 16'h8000, 16'h0);
        run_req("R7 abs long", 3'd6, 2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0, 16'hDEAD, 16'hBEEF);
        run_req("R8 pc ofs", 3'd3, 2'd1, 1'b1, 32'h5555_0000, 32'h0000_4000, 32'h0, 1'b0, 2'd0, 16'h0010, 16'h0);
        run_req("R8 pc idx", 3'd4, 2'd1, 1'b1, 32'h5555_0000, 32'h0000_4000, 32'h3, 1'b0, 2'd2, 16'h00FE, 16'h0);
        run_req("R11 pc_sel ind", 3'd0, 2'd1, 1'b1, 32'hAAAA_0000, 32'h1111_0000, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        run_req("R11 pc_sel post", 3'd1, 2'd1, 1'b1, 32'hAAAA_0000, 32'h1111_0000, 32'h0, 1'b0, 2'd0, 16'h0, 16'h0);
        idle_cycle();

        for (int i = 0; i < 400; i++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 6));
            run_req("R2-7 rand", m, 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom,
                    1'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));
            if ((i % 17) == 0) idle_cycle();
        end
        idle_cycle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule